// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation-buffer miss. It takes a virtual address, a process identifier and the access attributes (user or privileged, read or write). It first folds the process identifier into the low part of the address space. It then reads one or two descriptors from a translation table in physical memory and produces a physical address, a mapping size and access-permission bits. The finished entry goes out on a one-cycle fill port that a TLB can capture directly.

A first-level descriptor either maps a 1 MB section directly or points to a second-level table. A coarse table has 256 entries and a fine table has 1024 entries. A second-level descriptor maps a 64 KB, 4 KB or 1 KB page. A missing mapping or a denied access ends the walk with a fault pulse, and no fill is produced. The walker takes one request at a time and holds `busy` high while a walk is in flight.

Top module: `ptw_walker`

## Requirements
- R1: The modified address is `{pid, va[24:0]}` when `va[31:25]` is zero, and `va` unchanged otherwise. All table indexing uses the modified address, and the modified address is reported on `fill_mva` and `fault_addr`.
- R2: One cycle after a request is accepted, `mem_req_valid` pulses for exactly one cycle with address `{tbl_base, mva[31:20], 2'b00}`.
- R3: A first-level descriptor with type bits [1:0] = 00 ends the walk with `fault_kind` = 1, `fault_level` = 0 and no second fetch.
- R4: A first-level type of 10 is a section. It needs no second fetch, and it fills with `fill_pa = {d[31:20], mva[19:0]}`, `fill_size` = 0 and `fill_ap = d[11:10]`.
- R5: A first-level type of 01 (coarse table) issues a second fetch at `{d[31:10], mva[19:12], 2'b00}`.
- R6: A first-level type of 11 (fine table) issues a second fetch at `{d[31:12], mva[19:10], 2'b00}`.
- R7: A second-level descriptor with type 00 ends the walk with `fault_kind` = 2 and `fault_level` = 1.
- R8: Second-level types 01, 10 and 11 map large (64 KB), small (4 KB) and tiny (1 KB) pages. They fill with `fill_pa` = the descriptor above bit 16, 12 or 10 joined to the modified address below that bit, `fill_size` = 1, 2 or 3, and `fill_ap = d[5:4]`.
- R9: The permission code `ap` allows the access as follows. 11 allows everything. 10 allows privileged accesses and user reads. 01 allows privileged accesses only. 00 allows nothing. A denied access gives `fault_kind` = 3, with `fault_level` equal to the level of the leaf descriptor, and produces no fill.
- R10: `fill_valid` and `fault_valid` are one-cycle pulses and are never high together. `busy` drops in the cycle after either pulse.
- R11: `busy` rises in the cycle after a request is accepted. A `req_valid` that arrives while busy is ignored.
- R12: A walk waits any number of cycles for `mem_rsp_valid`. While it waits, the fetch address stays stable and no further request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_va | input | 32 | Virtual address to translate |
| req_user | input | 1 | 1 = user access, 0 = privileged |
| req_write | input | 1 | 1 = write access, 0 = read |
| pid | input | 7 | Process identifier for the remap |
| tbl_base | input | 18 | Bits [31:14] of the first-level table base |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Descriptor read request (one-cycle pulse) |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| fill_valid | output | 1 | Translation ready for the TLB |
| fill_mva | output | 32 | Modified virtual address of the entry |
| fill_pa | output | 32 | Translated physical address |
| fill_size | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| fill_ap | output | 2 | Permission code of the leaf descriptor |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_kind | output | 2 | 1 missing level one, 2 missing level two, 3 permission |
| fault_level | output | 1 | 0 level one, 1 level two |
| fault_addr | output | 32 | Modified address that faulted |

## Verification
The hardest case to reach is a permission denial on a second-level leaf that arrives after a slow memory response, with a stray request landing in the middle of the wait. The bench plays the memory itself. For each walk it answers with descriptors built from every type code, every permission code and every user and write combination. It varies the response delay from zero to three cycles and injects a spurious `req_valid` inside the wait. The expected address, size, permission bits and fault coding are then computed arithmetically from the descriptors it returned.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int AW      = 32;
    localparam int L1_IDX  = 20;  // section / first-level index boundary
    localparam int TB_LSB  = 14;  // first-level table alignment
    localparam int TBW     = AW - TB_LSB;
    localparam int LARGE_B = 16;
    localparam int SMALL_B = 12;
    localparam int TINY_B  = 10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
    } st_t;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0, SZ_LARGE = 2'd1, SZ_SMALL = 2'd2, SZ_TINY = 2'd3
    } size_t;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0, FK_XLAT1 = 2'd1, FK_XLAT2 = 2'd2, FK_PERM = 2'd3
    } fkind_t;

    typedef struct packed {
        st_t             st;
        logic [AW-1:0]   mva;
        logic [AW-1:0]   maddr;
        logic [AW-1:0]   pa;
        logic            user;
        logic            wr;
        size_t           size;
        logic [1:0]      ap;
        fkind_t          fk;
        logic            flvl;
    } walk_t;
endpackage

// File: rtl/ptw_remap.sv
module ptw_remap
    import ptw_pkg::*;
#(
    parameter int PID_W = 7
) (
    input  logic [AW-1:0]    va,
    input  logic [PID_W-1:0] pid,
    output logic [AW-1:0]    mva
);
    localparam int HI = AW - PID_W;

    always_comb begin
        if (va[AW-1:HI] == '0) mva = {pid, va[HI-1:0]};
        else                   mva = va;
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic          lvl2,
    input  logic [AW-1:0] desc,
    input  logic [AW-1:0] mva,
    output logic          is_fault,
    output logic          is_leaf,
    output logic [AW-1:0] next_addr,
    output logic [AW-1:0] pa,
    output size_t         size,
    output logic [1:0]    ap
);
    function automatic logic [AW-1:0] join_at(input logic [AW-1:0] hi_src,
                                              input logic [AW-1:0] lo_src,
                                              input int unsigned   b);
        logic [AW-1:0] m;
        m = (AW'(1) << b) - AW'(1);
        return (hi_src & ~m) | (lo_src & m);
    endfunction

    logic [1:0] typ;
    assign typ = desc[1:0];

    always_comb begin
        is_fault  = (typ == 2'b00);
        is_leaf   = 1'b0;
        size      = SZ_SECTION;
        ap        = desc[11:10];
        pa        = join_at(desc, mva, L1_IDX);
        next_addr = '0;
        if (!lvl2) begin
            is_leaf = (typ == 2'b10);
            if (typ == 2'b01)
                next_addr = {desc[AW-1:10], mva[19:12], 2'b00};
            else
                next_addr = {desc[AW-1:12], mva[19:10], 2'b00};
        end else begin
            is_leaf = 1'b1;
            ap      = desc[5:4];
            case (typ)
                2'b01:   begin size = SZ_LARGE; pa = join_at(desc, mva, LARGE_B); end
                2'b10:   begin size = SZ_SMALL; pa = join_at(desc, mva, SMALL_B); end
                default: begin size = SZ_TINY;  pa = join_at(desc, mva, TINY_B);  end
            endcase
        end
    end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
    input  logic [1:0] ap,
    input  logic       user,
    input  logic       wr,
    output logic       ok
);
    always_comb begin
        case (ap)
            2'b11:   ok = 1'b1;
            2'b10:   ok = !user || !wr;
            2'b01:   ok = !user;
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PID_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_va,
    input  logic             req_user,
    input  logic             req_write,
    input  logic [PID_W-1:0] pid,
    input  logic [TBW-1:0]   tbl_base,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [31:0]      mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_data,
    output logic             fill_valid,
    output logic [31:0]      fill_mva,
    output logic [31:0]      fill_pa,
    output logic [1:0]       fill_size,
    output logic [1:0]       fill_ap,
    output logic             fault_valid,
    output logic [1:0]       fault_kind,
    output logic             fault_level,
    output logic [31:0]      fault_addr
);
    walk_t r_q, r_d;

    logic [AW-1:0] mva_in;
    logic          dec_fault, dec_leaf, perm_ok, in_l2;
    logic [AW-1:0] dec_next, dec_pa;
    size_t         dec_size;
    logic [1:0]    dec_ap;

    ptw_remap #(.PID_W(PID_W)) i_remap (.va(req_va), .pid(pid), .mva(mva_in));

    assign in_l2 = (r_q.st == ST_L2_WAIT);

    ptw_desc_decode i_dec (
        .lvl2(in_l2), .desc(mem_rsp_data), .mva(r_q.mva),
        .is_fault(dec_fault), .is_leaf(dec_leaf), .next_addr(dec_next),
        .pa(dec_pa), .size(dec_size), .ap(dec_ap)
    );

    ptw_perm i_perm (.ap(dec_ap), .user(r_q.user), .wr(r_q.wr), .ok(perm_ok));

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: if (req_valid) begin
                r_d.mva   = mva_in;
                r_d.user  = req_user;
                r_d.wr    = req_write;
                r_d.maddr = {tbl_base, mva_in[AW-1:L1_IDX], 2'b00};
                r_d.fk    = FK_NONE;
                r_d.st    = ST_L1_REQ;
            end
            ST_L1_REQ: r_d.st = ST_L1_WAIT;
            ST_L2_REQ: r_d.st = ST_L2_WAIT;
            ST_L1_WAIT, ST_L2_WAIT: if (mem_rsp_valid) begin
                r_d.flvl = in_l2;
                if (dec_fault) begin
                    r_d.fk = in_l2 ? FK_XLAT2 : FK_XLAT1;
                    r_d.st = ST_FAULT;
                end else if (dec_leaf) begin
                    r_d.pa   = dec_pa;
                    r_d.size = dec_size;
                    r_d.ap   = dec_ap;
                    if (perm_ok) r_d.st = ST_DONE;
                    else begin
                        r_d.fk = FK_PERM;
                        r_d.st = ST_FAULT;
                    end
                end else begin
                    r_d.maddr = dec_next;
                    r_d.st    = ST_L2_REQ;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy          = (r_q.st != ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_L1_REQ) || (r_q.st == ST_L2_REQ);
    assign mem_req_addr  = r_q.maddr;
    assign fill_valid    = (r_q.st == ST_DONE);
    assign fill_mva      = r_q.mva;
    assign fill_pa       = r_q.pa;
    assign fill_size     = r_q.size;
    assign fill_ap       = r_q.ap;
    assign fault_valid   = (r_q.st == ST_FAULT);
    assign fault_kind    = r_q.fk;
    assign fault_level   = r_q.flvl;
    assign fault_addr    = r_q.mva;

    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && mem_req_valid));
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |=> !busy);
    a_r4_section_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_size == 2'd0) |-> (fill_pa[19:0] == fill_mva[19:0]));
    a_r8_small_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_size == 2'd2) |-> (fill_pa[11:0] == fill_mva[11:0]));
    a_r3_level_one: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_kind == 2'd1) |-> !fault_level);
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req_valid && !mem_rsp_valid && !fill_valid && !fault_valid)
        |=> ($stable(mem_req_addr) && !mem_req_valid));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  pid = '0;
    logic [17:0] tbl_base = '0;
    logic        busy, mem_req_valid, fill_valid, fault_valid, fault_level;
    logic [31:0] mem_req_addr, fill_mva, fill_pa, fault_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [1:0]  fill_size, fill_ap, fault_kind;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_user(req_user), .req_write(req_write), .pid(pid), .tbl_base(tbl_base),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_mva(fill_mva), .fill_pa(fill_pa),
        .fill_size(fill_size), .fill_ap(fill_ap), .fault_valid(fault_valid),
        .fault_kind(fault_kind), .fault_level(fault_level), .fault_addr(fault_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit perm_ok(input logic [1:0] ap, input bit u, input bit w);
        case (ap)
            2'b11:   return 1'b1;
            2'b10:   return !u || !w;
            2'b01:   return !u;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] joinb(input logic [31:0] h, input logic [31:0] l,
                                          input int b);
        logic [31:0] m;
        m = (32'd1 << b) - 32'd1;
        return (h & ~m) | (l & m);
    endfunction

    // Answer the outstanding fetch after dly extra cycles; optionally inject a stray request.
    task automatic respond(input logic [31:0] d, input int dly, input bit stray,
                           input logic [31:0] va);
        @(negedge clk);
        for (int k = 0; k < dly; k++) begin
            chk(busy && !mem_req_valid, "R12 waiting", {30'd0, busy, mem_req_valid}, 32'd2);
            if (stray && k == 0) begin
                req_valid = 1'b1; req_va = va ^ 32'hFFF0_0000;
            end
            @(negedge clk);
            req_valid = 1'b0; req_va = va;
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = d;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [6:0] p, input logic [17:0] tb,
                        input logic [31:0] l1, input logic [31:0] l2, input bit u,
                        input bit w, input int dly, input bit stray);
        logic [31:0] mva, l1a, l2a, epa;
        logic [1:0]  eap, esz, ek;
        bit          page, elvl;
        mva  = (va[31:25] == 7'd0) ? {p, va[24:0]} : va;
        l1a  = {tb, mva[31:20], 2'b00};
        page = (l1[1:0] == 2'b01) || (l1[1:0] == 2'b11);
        l2a  = (l1[1:0] == 2'b01) ? {l1[31:10], mva[19:12], 2'b00}
                                  : {l1[31:12], mva[19:10], 2'b00};
        ek = 2'd0; elvl = page; epa = '0; eap = '0; esz = '0;
        if (l1[1:0] == 2'b00) begin ek = 2'd1; elvl = 1'b0; end
        else if (!page) begin
            epa = joinb(l1, mva, 20); eap = l1[11:10]; esz = 2'd0;
        end else if (l2[1:0] == 2'b00) ek = 2'd2;
        else begin
            eap = l2[5:4];
            esz = l2[1:0];
            epa = joinb(l2, mva, (l2[1:0] == 2'b01) ? 16 : (l2[1:0] == 2'b10) ? 12 : 10);
        end
        if (ek == 2'd0 && !perm_ok(eap, u, w)) ek = 2'd3;

        @(negedge clk);
        req_va = va; pid = p; tbl_base = tb; req_user = u; req_write = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R11 busy after accept", {31'd0, busy}, 32'd1);
        chk(mem_req_valid && mem_req_addr == l1a, "R2 level-one fetch", mem_req_addr, l1a);
        respond(l1, dly, stray, va);
        if (page && l1[1:0] != 2'b00) begin
            chk(mem_req_valid && mem_req_addr == l2a,
                (l1[1:0] == 2'b01) ? "R5 coarse fetch" : "R6 fine fetch", mem_req_addr, l2a);
            respond(l2, dly, 1'b0, va);
        end else begin
            chk(!mem_req_valid, "R4 no second fetch", {31'd0, mem_req_valid}, 32'd0);
        end
        if (ek != 2'd0) begin
            chk(fault_valid && !fill_valid, "R9 fault without fill",
                {30'd0, fault_valid, fill_valid}, 32'd2);
            chk(fault_kind == ek, (ek == 2'd1) ? "R3 kind" : (ek == 2'd2) ? "R7 kind" : "R9 kind",
                {30'd0, fault_kind}, {30'd0, ek});
            chk(fault_level == elvl, "R9 fault level", {31'd0, fault_level}, {31'd0, elvl});
            chk(fault_addr == mva, "R1 fault address", fault_addr, mva);
        end else begin
            chk(fill_valid && !fault_valid, "R10 fill pulse",
                {30'd0, fill_valid, fault_valid}, 32'd2);
            chk(fill_mva == mva, "R1 modified address", fill_mva, mva);
            chk(fill_pa == epa, page ? "R8 page address" : "R4 section address", fill_pa, epa);
            chk(fill_size == esz, page ? "R8 size" : "R4 size", {30'd0, fill_size}, {30'd0, esz});
            chk(fill_ap == eap, page ? "R8 ap" : "R4 ap", {30'd0, fill_ap}, {30'd0, eap});
        end
        @(negedge clk);
        chk(!busy && !fill_valid && !fault_valid, "R10 release",
            {29'd0, busy, fill_valid, fault_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] x, va, l1, l2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R11 reset state",
            {28'd0, busy, mem_req_valid, fill_valid, fault_valid}, 32'd0);

        // remap boundary addresses
        walk(32'h01FF_FFFF, 7'h55, 18'h2_AAAA, 32'hABC0_0C02, 32'h0, 1'b1, 1'b1, 1, 1'b0);
        walk(32'h0200_0000, 7'h55, 18'h1_2345, 32'h1230_0C02, 32'h0, 1'b0, 1'b0, 0, 1'b0);
        walk(32'hFE00_1234, 7'h7F, 18'h3_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 2, 1'b1);

        n = 0;
        for (int t1 = 0; t1 < 4; t1++) begin
            for (int t2 = 0; t2 < 4; t2++) begin
                if ((t1 == 0 || t1 == 2) && t2 != 0) continue;
                for (int ap = 0; ap < 4; ap++) begin
                    for (int uw = 0; uw < 4; uw++) begin
                        n++;
                        x  = n * 32'h9E37_79B9 + 32'h1357_2468;
                        va = n[0] ? (x & 32'h01FF_FFFF) : (x | 32'h0200_0000);
                        l1 = ((x ^ 32'h5A5A_0000) & 32'hFFFF_F3FC) | (32'(ap) << 10) | 32'(t1);
                        l2 = ((x * 32'd7) & ~32'h0000_0033) | (32'(ap) << 4) | 32'(t2);
                        walk(va, 7'(n * 3), 18'(x >> 7), l1, l2, uw[1], uw[0],
                             n % 4, (n % 5 == 0) && (n % 4 != 0));
                    end
                end
            end
        end

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule